// File: doc/BRIEF.md
# Repair Rename Map with Selective Merge

This block keeps a second register rename table beside the normal speculative one. When a branch is found mispredicted, the mapping snapshot saved at that branch is loaded into the repair table, and the speculative table is left alone. Younger control-independent work keeps flowing through the speculative table.

The correct control-dependent instructions are renamed through the repair table. So are the re-injected duplicates of the data-dependent instructions. The control-independent, data-independent instructions that lie between them are never renamed a second time.

Each architectural register has a dirty bit that records whether the repair path wrote it since the last load. A repair lookup returns the written entry when the dirty bit is set, and the loaded snapshot value when it is not. When repair ends, a one-cycle merge command copies only the dirty entries into the speculative table. Every other speculative mapping, including ones written after the branch, keeps its value.

Top module: `rename_repair_map`

## Requirements
- R1: After reset both tables map architectural register i to physical tag i, and no register is dirty.
- R2: With `ckpt_load_i` high, the snapshot on `ckpt_map_i` is taken into the repair table at the clock edge. Entry r sits at bits [r*8 +: 8]. From the next cycle repair lookups return the snapshot, and the load does not change the speculative table.
- R3: A repair rename (`rep_valid_i` and `rep_ready_o` both high, `rep_dst_we_i` high) maps `rep_dst_i` to `rep_ptag_i` from the next cycle and marks that register dirty. In the request cycle the source lookups and `rep_old_ptag_o` give the mapping from before the write.
- R4: A repair lookup returns the written entry when the register is dirty, and the loaded snapshot value otherwise.
- R5: The speculative port works independently of the repair port. A speculative rename maps `spec_dst_i` to `spec_ptag_i` from the next cycle. Its lookups and `spec_old_ptag_o` give the mapping from before the write.
- R6: At a merge, each dirty register's repair entry is copied into the speculative table at the edge, and all dirty bits are cleared. Clean registers keep their speculative value, including values written after the branch.
- R7: In a cycle with `merge_i` high, both `rep_ready_o` and `spec_ready_o` are low, and a rename request on either port in that cycle changes no table.
- R8: A load clears every dirty bit, even while repair is in progress, and `rep_ready_o` is low in the load cycle. A merge in the same cycle as a load is ignored, so the speculative table is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ckpt_load_i | input | 1 | Load the branch snapshot into the repair table |
| ckpt_map_i | input | 256 | Snapshot; entry r at bits [r*8 +: 8] |
| rep_valid_i | input | 1 | Repair rename request |
| rep_src_a_i | input | 5 | Repair source A register |
| rep_src_b_i | input | 5 | Repair source B register |
| rep_dst_we_i | input | 1 | Repair request writes a destination |
| rep_dst_i | input | 5 | Repair destination register |
| rep_ptag_i | input | 8 | Newly allocated tag for the repair destination |
| rep_ready_o | output | 1 | Repair request accepted this cycle |
| rep_src_a_ptag_o | output | 8 | Repair lookup of source A |
| rep_src_b_ptag_o | output | 8 | Repair lookup of source B |
| rep_old_ptag_o | output | 8 | Repair mapping of the destination before the write |
| spec_valid_i | input | 1 | Speculative rename request |
| spec_src_a_i | input | 5 | Speculative source A register |
| spec_src_b_i | input | 5 | Speculative source B register |
| spec_dst_we_i | input | 1 | Speculative request writes a destination |
| spec_dst_i | input | 5 | Speculative destination register |
| spec_ptag_i | input | 8 | Newly allocated tag for the speculative destination |
| spec_ready_o | output | 1 | Speculative request accepted this cycle |
| spec_src_a_ptag_o | output | 8 | Speculative lookup of source A |
| spec_src_b_ptag_o | output | 8 | Speculative lookup of source B |
| spec_old_ptag_o | output | 8 | Speculative mapping of the destination before the write |
| merge_i | input | 1 | Copy dirty repair entries into the speculative table |

## Verification
The lookups and the ready outputs are combinational, so the bench drives a request at the falling edge and checks them one time unit later, in the same cycle. A rename, load or merge changes the tables at the next rising edge, so its effect is checked from the cycle after the request. The bench updates its model of the snapshot, repair entries, dirty bits and speculative table at that rising edge, and only when the request was accepted. After each phase, every one of the 32 registers is swept through both lookup ports and compared with the model.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  localparam int unsigned RRM_NUM_ARCH = 32;
  localparam int unsigned RRM_PTAG_W   = 8;
  localparam int unsigned RRM_NUM_RD   = 3;

  typedef enum logic [1:0] {
    RD_SRC_A = 2'd0,
    RD_SRC_B = 2'd1,
    RD_DST   = 2'd2
  } rd_port_e;
endpackage

// File: rtl/rrm_repair_table.sv
module rrm_repair_table #(
  parameter int unsigned NUM_ARCH = 32,
  parameter int unsigned PTAG_W   = 8,
  parameter int unsigned NUM_RD   = 3,
  localparam int unsigned AW      = $clog2(NUM_ARCH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [NUM_ARCH*PTAG_W-1:0] snap_i,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_idx_i,
  input  logic [PTAG_W-1:0]          wr_tag_i,
  input  logic                       clr_i,
  input  logic [AW-1:0]              rd_idx_i [NUM_RD],
  output logic [PTAG_W-1:0]          rd_tag_o [NUM_RD],
  output logic [NUM_ARCH*PTAG_W-1:0] ent_flat_o,
  output logic [NUM_ARCH-1:0]        dirty_o
);
  logic [PTAG_W-1:0]   snap_q [NUM_ARCH];
  logic [PTAG_W-1:0]   ent_q  [NUM_ARCH];
  logic [NUM_ARCH-1:0] dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ARCH; i++) begin
        snap_q[i] <= PTAG_W'(i);
        ent_q[i]  <= PTAG_W'(i);
      end
      dirty_q <= '0;
    end else if (load_i) begin
      for (int i = 0; i < NUM_ARCH; i++) snap_q[i] <= snap_i[i*PTAG_W +: PTAG_W];
      dirty_q <= '0;
    end else begin
      if (clr_i) dirty_q <= '0;
      if (wr_en_i) begin
        ent_q[wr_idx_i]   <= wr_tag_i;
        dirty_q[wr_idx_i] <= 1'b1;
      end
    end
  end

  // dirty entry wins, else the loaded snapshot
  for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
    assign rd_tag_o[k] = dirty_q[rd_idx_i[k]] ? ent_q[rd_idx_i[k]] : snap_q[rd_idx_i[k]];
  end

  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_flat
    assign ent_flat_o[i*PTAG_W +: PTAG_W] = ent_q[i];
  end

  assign dirty_o = dirty_q;
endmodule

// File: rtl/rrm_spec_table.sv
module rrm_spec_table #(
  parameter int unsigned NUM_ARCH = 32,
  parameter int unsigned PTAG_W   = 8,
  parameter int unsigned NUM_RD   = 3,
  localparam int unsigned AW      = $clog2(NUM_ARCH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_idx_i,
  input  logic [PTAG_W-1:0]          wr_tag_i,
  input  logic                       merge_i,
  input  logic [NUM_ARCH-1:0]        merge_mask_i,
  input  logic [NUM_ARCH*PTAG_W-1:0] merge_data_i,
  input  logic [AW-1:0]              rd_idx_i [NUM_RD],
  output logic [PTAG_W-1:0]          rd_tag_o [NUM_RD],
  output logic [NUM_ARCH*PTAG_W-1:0] map_flat_o
);
  logic [PTAG_W-1:0] map_q [NUM_ARCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PTAG_W'(i);
    end else if (merge_i) begin
      for (int i = 0; i < NUM_ARCH; i++)
        if (merge_mask_i[i]) map_q[i] <= merge_data_i[i*PTAG_W +: PTAG_W];
    end else if (wr_en_i) begin
      map_q[wr_idx_i] <= wr_tag_i;
    end
  end

  for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
    assign rd_tag_o[k] = map_q[rd_idx_i[k]];
  end

  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_flat
    assign map_flat_o[i*PTAG_W +: PTAG_W] = map_q[i];
  end
endmodule

// File: rtl/rename_repair_map.sv
module rename_repair_map
  import rrm_pkg::*;
#(
  parameter int unsigned NUM_ARCH = RRM_NUM_ARCH,
  parameter int unsigned PTAG_W   = RRM_PTAG_W,
  localparam int unsigned AW      = $clog2(NUM_ARCH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ckpt_load_i,
  input  logic [NUM_ARCH*PTAG_W-1:0] ckpt_map_i,
  input  logic                       rep_valid_i,
  input  logic [AW-1:0]              rep_src_a_i,
  input  logic [AW-1:0]              rep_src_b_i,
  input  logic                       rep_dst_we_i,
  input  logic [AW-1:0]              rep_dst_i,
  input  logic [PTAG_W-1:0]          rep_ptag_i,
  output logic                       rep_ready_o,
  output logic [PTAG_W-1:0]          rep_src_a_ptag_o,
  output logic [PTAG_W-1:0]          rep_src_b_ptag_o,
  output logic [PTAG_W-1:0]          rep_old_ptag_o,
  input  logic                       spec_valid_i,
  input  logic [AW-1:0]              spec_src_a_i,
  input  logic [AW-1:0]              spec_src_b_i,
  input  logic                       spec_dst_we_i,
  input  logic [AW-1:0]              spec_dst_i,
  input  logic [PTAG_W-1:0]          spec_ptag_i,
  output logic                       spec_ready_o,
  output logic [PTAG_W-1:0]          spec_src_a_ptag_o,
  output logic [PTAG_W-1:0]          spec_src_b_ptag_o,
  output logic [PTAG_W-1:0]          spec_old_ptag_o,
  input  logic                       merge_i
);
  localparam int unsigned NRD = RRM_NUM_RD;

  logic                       rep_wr, spec_wr, merge_go;
  logic [NUM_ARCH-1:0]        rep_dirty;
  logic [NUM_ARCH*PTAG_W-1:0] rep_ent_flat;
  logic [NUM_ARCH*PTAG_W-1:0] spec_flat;
  logic [AW-1:0]              rep_rd_idx  [NRD];
  logic [AW-1:0]              spec_rd_idx [NRD];
  logic [PTAG_W-1:0]          rep_rd_tag  [NRD];
  logic [PTAG_W-1:0]          spec_rd_tag [NRD];

  // merge blocks both ports; a load blocks the repair port and overrides merge
  assign rep_ready_o  = !merge_i && !ckpt_load_i;
  assign spec_ready_o = !merge_i;
  assign merge_go     = merge_i && !ckpt_load_i;
  assign rep_wr       = rep_valid_i && rep_ready_o && rep_dst_we_i;
  assign spec_wr      = spec_valid_i && spec_ready_o && spec_dst_we_i;

  assign rep_rd_idx[RD_SRC_A]  = rep_src_a_i;
  assign rep_rd_idx[RD_SRC_B]  = rep_src_b_i;
  assign rep_rd_idx[RD_DST]    = rep_dst_i;
  assign spec_rd_idx[RD_SRC_A] = spec_src_a_i;
  assign spec_rd_idx[RD_SRC_B] = spec_src_b_i;
  assign spec_rd_idx[RD_DST]   = spec_dst_i;

  rrm_repair_table #(.NUM_ARCH(NUM_ARCH), .PTAG_W(PTAG_W), .NUM_RD(NRD)) u_repair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ckpt_load_i),
    .snap_i     (ckpt_map_i),
    .wr_en_i    (rep_wr),
    .wr_idx_i   (rep_dst_i),
    .wr_tag_i   (rep_ptag_i),
    .clr_i      (merge_go),
    .rd_idx_i   (rep_rd_idx),
    .rd_tag_o   (rep_rd_tag),
    .ent_flat_o (rep_ent_flat),
    .dirty_o    (rep_dirty)
  );

  rrm_spec_table #(.NUM_ARCH(NUM_ARCH), .PTAG_W(PTAG_W), .NUM_RD(NRD)) u_spec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (spec_wr),
    .wr_idx_i     (spec_dst_i),
    .wr_tag_i     (spec_ptag_i),
    .merge_i      (merge_go),
    .merge_mask_i (rep_dirty),
    .merge_data_i (rep_ent_flat),
    .rd_idx_i     (spec_rd_idx),
    .rd_tag_o     (spec_rd_tag),
    .map_flat_o   (spec_flat)
  );

  assign rep_src_a_ptag_o  = rep_rd_tag[RD_SRC_A];
  assign rep_src_b_ptag_o  = rep_rd_tag[RD_SRC_B];
  assign rep_old_ptag_o    = rep_rd_tag[RD_DST];
  assign spec_src_a_ptag_o = spec_rd_tag[RD_SRC_A];
  assign spec_src_b_ptag_o = spec_rd_tag[RD_SRC_B];
  assign spec_old_ptag_o   = spec_rd_tag[RD_DST];
endmodule

// File: rtl/rrm_checker.sv
module rrm_checker #(
  parameter int unsigned NUM_ARCH = 32,
  parameter int unsigned PTAG_W   = 8,
  localparam int unsigned AW      = $clog2(NUM_ARCH)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       ckpt_load_i,
  input logic                       merge_i,
  input logic                       rep_valid_i,
  input logic                       rep_dst_we_i,
  input logic [AW-1:0]              rep_dst_i,
  input logic                       rep_ready_o,
  input logic                       spec_valid_i,
  input logic                       spec_dst_we_i,
  input logic                       spec_ready_o,
  input logic [NUM_ARCH-1:0]        dirty_i,
  input logic [NUM_ARCH*PTAG_W-1:0] spec_flat_i
);
  p_merge_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_i |-> (!rep_ready_o && !spec_ready_o));

  p_load_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_load_i |-> !rep_ready_o);

  p_load_clears_dirty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_load_i |=> (dirty_i == '0));

  p_merge_clears_dirty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_i |=> (dirty_i == '0));

  p_write_marks_dirty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_valid_i && rep_ready_o && rep_dst_we_i) |=> dirty_i[$past(rep_dst_i)]);

  p_load_keeps_spec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ckpt_load_i && !(spec_valid_i && spec_dst_we_i)) |=> $stable(spec_flat_i));
endmodule

bind rename_repair_map rrm_checker #(.NUM_ARCH(NUM_ARCH), .PTAG_W(PTAG_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ckpt_load_i   (ckpt_load_i),
  .merge_i       (merge_i),
  .rep_valid_i   (rep_valid_i),
  .rep_dst_we_i  (rep_dst_we_i),
  .rep_dst_i     (rep_dst_i),
  .rep_ready_o   (rep_ready_o),
  .spec_valid_i  (spec_valid_i),
  .spec_dst_we_i (spec_dst_we_i),
  .spec_ready_o  (spec_ready_o),
  .dirty_i       (rep_dirty),
  .spec_flat_i   (spec_flat)
);

// File: tb/tb_rename_repair_map.sv
module tb_rename_repair_map;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 32;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ckpt_load_i = 1'b0;
  logic [NA*PW-1:0] ckpt_map_i = '0;
  logic rep_valid_i = 1'b0, rep_dst_we_i = 1'b0;
  logic [4:0] rep_src_a_i = '0, rep_src_b_i = '0, rep_dst_i = '0;
  logic [PW-1:0] rep_ptag_i = '0;
  logic rep_ready_o;
  logic [PW-1:0] rep_src_a_ptag_o, rep_src_b_ptag_o, rep_old_ptag_o;
  logic spec_valid_i = 1'b0, spec_dst_we_i = 1'b0;
  logic [4:0] spec_src_a_i = '0, spec_src_b_i = '0, spec_dst_i = '0;
  logic [PW-1:0] spec_ptag_i = '0;
  logic spec_ready_o;
  logic [PW-1:0] spec_src_a_ptag_o, spec_src_b_ptag_o, spec_old_ptag_o;
  logic merge_i = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_repair_map dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ckpt_load_i(ckpt_load_i), .ckpt_map_i(ckpt_map_i),
    .rep_valid_i(rep_valid_i), .rep_src_a_i(rep_src_a_i), .rep_src_b_i(rep_src_b_i),
    .rep_dst_we_i(rep_dst_we_i), .rep_dst_i(rep_dst_i), .rep_ptag_i(rep_ptag_i),
    .rep_ready_o(rep_ready_o), .rep_src_a_ptag_o(rep_src_a_ptag_o),
    .rep_src_b_ptag_o(rep_src_b_ptag_o), .rep_old_ptag_o(rep_old_ptag_o),
    .spec_valid_i(spec_valid_i), .spec_src_a_i(spec_src_a_i), .spec_src_b_i(spec_src_b_i),
    .spec_dst_we_i(spec_dst_we_i), .spec_dst_i(spec_dst_i), .spec_ptag_i(spec_ptag_i),
    .spec_ready_o(spec_ready_o), .spec_src_a_ptag_o(spec_src_a_ptag_o),
    .spec_src_b_ptag_o(spec_src_b_ptag_o), .spec_old_ptag_o(spec_old_ptag_o),
    .merge_i(merge_i)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int m_spec [NA];
  int m_snap [NA];
  int m_rep  [NA];
  bit m_dirty [NA];

  function automatic int rep_eff(int r);
    return m_dirty[r] ? m_rep[r] : m_snap[r];
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // full sweep of both lookup ports, model compared per register
  task automatic sweep(input string req);
    for (int r = 0; r < NA; r++) begin
      @(negedge clk);
      rep_src_a_i = 5'(r);  rep_src_b_i = 5'(NA-1-r);
      spec_src_a_i = 5'(r); spec_src_b_i = 5'(NA-1-r);
      #1;
      check(req, "rep_a", int'(rep_src_a_ptag_o), rep_eff(r));
      check(req, "rep_b", int'(rep_src_b_ptag_o), rep_eff(NA-1-r));
      check(req, "spec_a", int'(spec_src_a_ptag_o), m_spec[r]);
      check(req, "spec_b", int'(spec_src_b_ptag_o), m_spec[NA-1-r]);
    end
  endtask

  task automatic do_load(input int seed, input int mul);
    @(negedge clk);
    for (int r = 0; r < NA; r++) ckpt_map_i[r*PW +: PW] = PW'(r*mul + seed);
    ckpt_load_i = 1'b1;
    #1;
    check("R8", "rep_ready in load", int'(rep_ready_o), 0);
    @(posedge clk); #1;
    for (int r = 0; r < NA; r++) begin
      m_snap[r] = (r*mul + seed) & 255;
      m_dirty[r] = 0;
    end
    ckpt_load_i = 1'b0;
  endtask

  task automatic rep_rename(input int dst, input int tag);
    @(negedge clk);
    rep_valid_i = 1'b1; rep_dst_we_i = 1'b1;
    rep_dst_i = 5'(dst); rep_ptag_i = PW'(tag); rep_src_a_i = 5'(dst);
    #1;
    check("R3", "rep_ready", int'(rep_ready_o), 1);
    check("R3", "rep_old", int'(rep_old_ptag_o), rep_eff(dst));
    check("R3", "rep_src_same_cycle", int'(rep_src_a_ptag_o), rep_eff(dst));
    @(posedge clk); #1;
    m_rep[dst] = tag; m_dirty[dst] = 1;
    rep_valid_i = 1'b0; rep_dst_we_i = 1'b0;
  endtask

  task automatic spec_rename(input int dst, input int tag);
    @(negedge clk);
    spec_valid_i = 1'b1; spec_dst_we_i = 1'b1;
    spec_dst_i = 5'(dst); spec_ptag_i = PW'(tag); spec_src_b_i = 5'(dst);
    #1;
    check("R5", "spec_old", int'(spec_old_ptag_o), m_spec[dst]);
    check("R5", "spec_src_same_cycle", int'(spec_src_b_ptag_o), m_spec[dst]);
    @(posedge clk); #1;
    m_spec[dst] = tag;
    spec_valid_i = 1'b0; spec_dst_we_i = 1'b0;
  endtask

  initial begin
    for (int r = 0; r < NA; r++) begin
      m_spec[r] = r; m_snap[r] = r; m_rep[r] = r; m_dirty[r] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: identity maps after reset
    @(negedge clk); #1;
    check("R1", "rep_ready", int'(rep_ready_o), 1);
    check("R1", "spec_ready", int'(spec_ready_o), 1);
    sweep("R1");

    // R5: speculative path writes after the branch
    for (int r = 0; r < NA; r += 3) spec_rename(r, 100 + r);
    sweep("R5");

    // R2: load snapshot, speculative table untouched
    do_load(11, 37);
    sweep("R2");

    // R3/R4: repair writes on a subset, rest still snapshot
    for (int r = 1; r < NA; r += 4) rep_rename(r, 200 + r);
    rep_rename(5, 77);
    sweep("R4");

    // R8: reload mid-repair clears all dirty bits
    do_load(200, 53);
    sweep("R8");

    // R6/R7: new repair set, then merge with colliding requests
    for (int r = 0; r < NA; r += 5) rep_rename(r, 150 + r);
    @(negedge clk);
    merge_i = 1'b1;
    rep_valid_i = 1'b1; rep_dst_we_i = 1'b1; rep_dst_i = 5'd2; rep_ptag_i = 8'd77;
    spec_valid_i = 1'b1; spec_dst_we_i = 1'b1; spec_dst_i = 5'd3; spec_ptag_i = 8'd88;
    #1;
    check("R7", "rep_ready in merge", int'(rep_ready_o), 0);
    check("R7", "spec_ready in merge", int'(spec_ready_o), 0);
    @(posedge clk); #1;
    for (int r = 0; r < NA; r++) begin
      if (m_dirty[r]) m_spec[r] = m_rep[r];
      m_dirty[r] = 0;
    end
    merge_i = 1'b0; rep_valid_i = 1'b0; rep_dst_we_i = 1'b0;
    spec_valid_i = 1'b0; spec_dst_we_i = 1'b0;
    sweep("R6");

    // R8: merge together with load is ignored
    for (int r = 3; r < NA; r += 7) rep_rename(r, 60 + r);
    @(negedge clk);
    for (int r = 0; r < NA; r++) ckpt_map_i[r*PW +: PW] = PW'(r*29 + 5);
    ckpt_load_i = 1'b1; merge_i = 1'b1;
    @(posedge clk); #1;
    for (int r = 0; r < NA; r++) begin
      m_snap[r] = (r*29 + 5) & 255;
      m_dirty[r] = 0;
    end
    ckpt_load_i = 1'b0; merge_i = 1'b0;
    sweep("R8");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule